// File: doc/BRIEF.md
# Write Command Release Gate

The gate sits on the write side of a memory port. Write address commands are accepted into a small in-order command queue. Write data beats are accepted into a local data FIFO. A command is passed downstream only after enough of its own data has been buffered. Data beats are forwarded downstream only for bursts whose command has already been released, so the downstream port never waits on data that is still upstream.

A single configuration word sets the release behaviour. In last-beat mode a command waits until the beat carrying WLAST has been buffered. In threshold mode it waits for a programmed number of beats, 1 to 16. WLAST still releases it early if the burst is shorter than the threshold. A promotion enable makes a rise of the incoming QoS value lift every command already waiting in the queue. With the enable clear, only later commands carry the new QoS.

Configuration is written only while the block is held in its block-level reset (`blk_rst_i` high). That reset also empties the queue, the FIFO and all release bookkeeping.

Top module: `wr_cmd_gate`

## Requirements
- R1: The configuration word reads as follows. Bits 11:8 hold the threshold T. Bits 5:4 hold the mode, where 00 is last-beat and 01 is threshold. Bit 3 holds the promotion enable. All other bits read zero. After `rst_ni` the word reads 0x00000F00.
- R2: A configuration write takes effect only in a cycle with `blk_rst_i` high. A write with `blk_rst_i` low leaves the word unchanged.
- R3: A write whose mode bits are 10 or 11 stores mode 00.
- R4: In mode 00, the head command is not offered downstream until the WLAST beat of its burst has been accepted. It is offered in the cycle after that beat is accepted.
- R5: In mode 01 with threshold T, the head command is offered in the cycle after the (T+1)-th beat of its burst is accepted, and not before.
- R6: In mode 01, a burst whose WLAST is accepted before beat T+1 releases its command in the cycle after WLAST.
- R7: Beats are matched to commands in arrival order, and beats may arrive before their command. Commands and data leave in order, with addresses, lengths and data unchanged. No data beat of a burst leaves before that burst's command has been accepted downstream.
- R8: With promotion enabled, a rise of `aw_qos_i` raises every queued command whose QoS is lower to the new value, from the next cycle.
- R9: With promotion disabled, queued commands keep their QoS. Commands accepted later carry the QoS present when they were accepted.
- R10: `aw_ready_o` is low while the command queue holds DEPTH entries. `w_ready_o` is low while the data FIFO holds FIFO_DEPTH beats.
- R11: While `blk_rst_i` is high, `aw_ready_o`, `w_ready_o`, `out_aw_valid_o` and `out_w_valid_o` are low. Any queued commands and data are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_rst_i | input | 1 | Block-level hold reset; enables configuration writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| aw_valid_i | input | 1 | Incoming command valid |
| aw_ready_o | output | 1 | Incoming command ready |
| aw_addr_i | input | ADDR_W | Incoming command address |
| aw_len_i | input | 8 | Incoming burst length minus one |
| aw_qos_i | input | 4 | Incoming QoS |
| w_valid_i | input | 1 | Incoming data valid |
| w_ready_o | output | 1 | Incoming data ready |
| w_data_i | input | DATA_W | Incoming data |
| w_last_i | input | 1 | Incoming last beat of burst |
| out_aw_valid_o | output | 1 | Released command valid |
| out_aw_ready_i | input | 1 | Released command ready |
| out_aw_addr_o | output | ADDR_W | Released command address |
| out_aw_len_o | output | 8 | Released command length |
| out_aw_qos_o | output | 4 | Released command QoS |
| out_w_valid_o | output | 1 | Forwarded data valid |
| out_w_ready_i | input | 1 | Forwarded data ready |
| out_w_data_o | output | DATA_W | Forwarded data |
| out_w_last_o | output | 1 | Forwarded last beat |

## Verification
All input-side ready signals and the read data are combinational from state, so the bench samples them one time unit after the falling edge at which it drives inputs. The release decision is registered. `out_aw_valid_o` therefore rises one cycle after the edge that accepts the deciding beat, and the bench checks it at the falling edge that follows that acceptance. It also checks that the signal is still low after the beat before. A QoS promotion shows on `out_aw_qos_o` one cycle after the rising input. Handshakes in the random phase are recorded from values that are stable before the rising edge, with one check per transfer.

// File: rtl/wcg_pkg.sv
`timescale 1ns/1ps
package wcg_pkg;
  localparam int unsigned QOS_W = 4;
  localparam int unsigned LEN_W = 8;
  localparam int unsigned THR_W = 4;

  typedef enum logic [1:0] {
    REL_ON_LAST = 2'b00,
    REL_ON_THR  = 2'b01
  } rel_mode_e;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    rel_mode_e        mode;
    logic             promo_en;
  } gate_cfg_t;
endpackage

// File: rtl/wcg_cfg_reg.sv
`timescale 1ns/1ps
module wcg_cfg_reg
  import wcg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        blk_rst_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output gate_cfg_t   cfg_o
);
  gate_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.thr      <= '1;
      cfg_q.mode     <= REL_ON_LAST;
      cfg_q.promo_en <= 1'b0;
    end else if (we_i && blk_rst_i) begin
      cfg_q.thr      <= wdata_i[11:8];
      // reserved encodings fall back to last-beat release
      cfg_q.mode     <= (wdata_i[5:4] == 2'b01) ? REL_ON_THR : REL_ON_LAST;
      cfg_q.promo_en <= wdata_i[3];
    end
  end

  always_comb begin
    rdata_o        = '0;
    rdata_o[11:8]  = cfg_q.thr;
    rdata_o[5:4]   = cfg_q.mode;
    rdata_o[3]     = cfg_q.promo_en;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wcg_cmd_queue.sv
`timescale 1ns/1ps
module wcg_cmd_queue
  import wcg_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic [QOS_W-1:0]  qos_in_i,
  input  logic              pop_i,
  input  logic              promo_en_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [LEN_W-1:0]  head_len_o,
  output logic [QOS_W-1:0]  head_qos_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];
  logic [QOS_W-1:0]  qos_q  [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [QOS_W-1:0]  qos_prev_q;
  logic              promote;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign promote = promo_en_i && (qos_in_i > qos_prev_q);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
      qos_prev_q <= '0;
    end else begin
      qos_prev_q <= qos_in_i;
      if (clr_i) begin
        wptr_q <= '0;
        rptr_q <= '0;
        cnt_q  <= '0;
      end else begin
        if (push_i) wptr_q <= nxt(wptr_q);
        if (pop_i)  rptr_q <= nxt(rptr_q);
        cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wptr_q == PTR_W'(i)) begin
        addr_q[i] <= push_addr_i;
        len_q[i]  <= push_len_i;
        qos_q[i]  <= qos_in_i;
      end else if (promote && qos_q[i] < qos_in_i) begin
        qos_q[i]  <= qos_in_i;
      end
    end
  end

  assign head_addr_o = addr_q[rptr_q];
  assign head_len_o  = len_q[rptr_q];
  assign head_qos_o  = qos_q[rptr_q];
endmodule

// File: rtl/wcg_data_fifo.sv
`timescale 1ns/1ps
module wcg_data_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= {last_i, data_i};
  end

  assign {last_o, data_o} = mem_q[rptr_q];
endmodule

// File: rtl/wcg_release_ctrl.sv
`timescale 1ns/1ps
module wcg_release_ctrl
  import wcg_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  gate_cfg_t        cfg_i,
  input  logic             beat_in_i,
  input  logic             beat_last_i,
  input  logic             cmd_out_i,
  input  logic             last_out_i,
  output logic             rel_ok_o,
  output logic             w_open_o
);
  logic [THR_W-1:0] acc_q;      // beats of the accumulating burst
  logic             met_q;      // accumulating burst already credited
  logic [CNT_W-1:0] credit_q;   // bursts ready for release
  logic [CNT_W-1:0] grant_q;    // released bursts with data pending
  logic             hit;

  always_comb begin
    hit = 1'b0;
    if (beat_in_i && !met_q)
      hit = beat_last_i || (cfg_i.mode == REL_ON_THR && acc_q == cfg_i.thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      met_q    <= 1'b0;
      credit_q <= '0;
      grant_q  <= '0;
    end else if (clr_i) begin
      acc_q    <= '0;
      met_q    <= 1'b0;
      credit_q <= '0;
      grant_q  <= '0;
    end else begin
      if (beat_in_i) begin
        if (beat_last_i) begin
          acc_q <= '0;
          met_q <= 1'b0;
        end else begin
          if (!met_q) acc_q <= acc_q + 1'b1;
          if (hit)    met_q <= 1'b1;
        end
      end
      credit_q <= credit_q + CNT_W'(hit) - CNT_W'(cmd_out_i);
      grant_q  <= grant_q + CNT_W'(cmd_out_i) - CNT_W'(last_out_i);
    end
  end

  assign rel_ok_o = (credit_q != '0);
  assign w_open_o = (grant_q != '0);
endmodule

// File: rtl/wr_cmd_gate.sv
`timescale 1ns/1ps
module wr_cmd_gate
  import wcg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned FIFO_DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_rst_i,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic [7:0]        aw_len_i,
  input  logic [3:0]        aw_qos_i,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  input  logic [DATA_W-1:0] w_data_i,
  input  logic              w_last_i,
  output logic              out_aw_valid_o,
  input  logic              out_aw_ready_i,
  output logic [ADDR_W-1:0] out_aw_addr_o,
  output logic [7:0]        out_aw_len_o,
  output logic [3:0]        out_aw_qos_o,
  output logic              out_w_valid_o,
  input  logic              out_w_ready_i,
  output logic [DATA_W-1:0] out_w_data_o,
  output logic              out_w_last_o
);
  localparam int unsigned CRED_W = $clog2(FIFO_DEPTH + DEPTH + 1) + 1;

  gate_cfg_t cfg;
  logic q_full, q_empty, f_full, f_empty;
  logic aw_hs, w_hs, oaw_hs, ow_hs;
  logic rel_ok, w_open;

  assign aw_ready_o     = !q_full && !blk_rst_i;
  assign w_ready_o      = !f_full && !blk_rst_i;
  assign out_aw_valid_o = !q_empty && rel_ok && !blk_rst_i;
  assign out_w_valid_o  = !f_empty && w_open && !blk_rst_i;

  assign aw_hs  = aw_valid_i && aw_ready_o;
  assign w_hs   = w_valid_i && w_ready_o;
  assign oaw_hs = out_aw_valid_o && out_aw_ready_i;
  assign ow_hs  = out_w_valid_o && out_w_ready_i;

  wcg_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blk_rst_i(blk_rst_i),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .cfg_o    (cfg)
  );

  wcg_cmd_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cmdq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (blk_rst_i),
    .push_i     (aw_hs),
    .push_addr_i(aw_addr_i),
    .push_len_i (aw_len_i),
    .qos_in_i   (aw_qos_i),
    .pop_i      (oaw_hs),
    .promo_en_i (cfg.promo_en),
    .full_o     (q_full),
    .empty_o    (q_empty),
    .head_addr_o(out_aw_addr_o),
    .head_len_o (out_aw_len_o),
    .head_qos_o (out_aw_qos_o)
  );

  wcg_data_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_wfifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (blk_rst_i),
    .push_i (w_hs),
    .data_i (w_data_i),
    .last_i (w_last_i),
    .pop_i  (ow_hs),
    .data_o (out_w_data_o),
    .last_o (out_w_last_o),
    .full_o (f_full),
    .empty_o(f_empty)
  );

  wcg_release_ctrl #(.CNT_W(CRED_W)) u_rel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (blk_rst_i),
    .cfg_i      (cfg),
    .beat_in_i  (w_hs),
    .beat_last_i(w_last_i),
    .cmd_out_i  (oaw_hs),
    .last_out_i (ow_hs && out_w_last_o),
    .rel_ok_o   (rel_ok),
    .w_open_o   (w_open)
  );
endmodule

// File: rtl/wr_cmd_gate_chk.sv
`timescale 1ns/1ps
module wr_cmd_gate_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              blk_rst_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              aw_ready_o,
  input logic              w_ready_o,
  input logic              q_full,
  input logic              f_full,
  input logic              out_aw_valid_o,
  input logic              out_aw_ready_i,
  input logic [ADDR_W-1:0] out_aw_addr_o,
  input logic              out_w_valid_o
);
  // R11
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_rst_i |-> !aw_ready_o && !w_ready_o && !out_aw_valid_o && !out_w_valid_o);

  // R2
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_rst_i |=> $stable(cfg_rdata_o));

  // R1
  cfg_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[31:12] == '0 && cfg_rdata_o[7:6] == '0 && cfg_rdata_o[2:0] == '0);

  // R10
  q_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full |-> !aw_ready_o);

  // R10
  f_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_full |-> !w_ready_o);

  // R7
  aw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || blk_rst_i)
    out_aw_valid_o && !out_aw_ready_i |=> (out_aw_valid_o || blk_rst_i) && $stable(out_aw_addr_o));
endmodule

bind wr_cmd_gate wr_cmd_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .blk_rst_i     (blk_rst_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .aw_ready_o    (aw_ready_o),
  .w_ready_o     (w_ready_o),
  .q_full        (q_full),
  .f_full        (f_full),
  .out_aw_valid_o(out_aw_valid_o),
  .out_aw_ready_i(out_aw_ready_i),
  .out_aw_addr_o (out_aw_addr_o),
  .out_w_valid_o (out_w_valid_o)
);

// File: tb/wr_cmd_gate_tb_top.sv
`timescale 1ns/1ps
module wr_cmd_gate_tb_top;
  localparam int AW = 32, DW = 32, QD = 8, FD = 32, NB = 40;

  logic clk = 1'b0, rst_ni = 1'b0, blk_rst = 1'b1;
  logic cfg_we = 1'b0; logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic aw_valid = 1'b0, aw_ready; logic [AW-1:0] aw_addr = '0;
  logic [7:0] aw_len = '0; logic [3:0] aw_qos = '0;
  logic w_valid = 1'b0, w_ready, w_last = 1'b0; logic [DW-1:0] w_data = '0;
  logic oaw_valid, oaw_ready = 1'b0; logic [AW-1:0] oaw_addr;
  logic [7:0] oaw_len; logic [3:0] oaw_qos;
  logic ow_valid, ow_ready = 1'b0, ow_last; logic [DW-1:0] ow_data;

  int checks = 0, errors = 0;
  bit rnd_on = 1'b0, done = 1'b0;
  int ai = 0, wi = 0, wb = 0;
  logic [7:0] rlen [NB];

  always #2.5 clk = ~clk;

  wr_cmd_gate #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(QD), .FIFO_DEPTH(FD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .blk_rst_i(blk_rst),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .aw_valid_i(aw_valid), .aw_ready_o(aw_ready), .aw_addr_i(aw_addr),
    .aw_len_i(aw_len), .aw_qos_i(aw_qos),
    .w_valid_i(w_valid), .w_ready_o(w_ready), .w_data_i(w_data), .w_last_i(w_last),
    .out_aw_valid_o(oaw_valid), .out_aw_ready_i(oaw_ready), .out_aw_addr_o(oaw_addr),
    .out_aw_len_o(oaw_len), .out_aw_qos_o(oaw_qos),
    .out_w_valid_o(ow_valid), .out_w_ready_i(ow_ready), .out_w_data_o(ow_data),
    .out_w_last_o(ow_last)
  );

  function automatic logic [31:0] cfg_word(input logic [3:0] t, input logic [1:0] m, input logic e);
    logic [1:0] ms = (m == 2'b01) ? 2'b01 : 2'b00;
    return {20'd0, t, 2'b00, ms, e, 3'b000};
  endfunction

  function automatic logic [DW-1:0] beat_val(input int b, input int k);
    return DW'((b << 16) | k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic cfg_wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // restart with a new configuration
  task automatic setup(input logic [31:0] v);
    @(negedge clk); blk_rst = 1'b1;
    cfg_wr(v);
    @(negedge clk); blk_rst = 1'b0;
  endtask

  task automatic push_aw(input logic [AW-1:0] a, input logic [7:0] l, input logic [3:0] q);
    bit hs = 1'b0;
    @(negedge clk);
    aw_valid = 1'b1; aw_addr = a; aw_len = l; aw_qos = q;
    while (!hs) begin
      #1 hs = aw_ready;
      @(negedge clk);
    end
    aw_valid = 1'b0;
  endtask

  task automatic push_w(input logic [DW-1:0] d, input logic l);
    bit hs = 1'b0;
    w_valid = 1'b1; w_data = d; w_last = l;
    while (!hs) begin
      #1 hs = w_ready;
      @(negedge clk);
    end
    w_valid = 1'b0; w_last = 1'b0;
  endtask

  task automatic pop_aw(input logic [AW-1:0] a, input logic [3:0] q, input string req);
    #1;
    chk(oaw_valid, req, 32'(oaw_valid), 32'd1);
    chk(oaw_addr == a, req, oaw_addr, a);
    chk(oaw_qos == q, req, 32'(oaw_qos), 32'(q));
    oaw_ready = 1'b1;
    @(negedge clk); oaw_ready = 1'b0;
  endtask

  // random phase monitor: values stable before the rising edge
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rnd_on) begin
        if (ow_valid && ow_ready) begin
          chk(wi < ai, "R7 data after cmd", 32'(wi), 32'(ai));
          chk(ow_data == beat_val(wi, wb) && ow_last == (wb == int'(rlen[wi])),
              "R7 data order", ow_data, beat_val(wi, wb));
          if (ow_last) begin wi++; wb = 0; end else wb++;
        end
        if (oaw_valid && oaw_ready) begin
          chk(oaw_addr == AW'(ai * 64) && oaw_len == rlen[ai], "R7 cmd order",
              oaw_addr, 32'(ai * 64));
          ai++;
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0077));
    #12 rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(cfg_rdata == 32'h0000_0F00, "R1 reset value", cfg_rdata, 32'h0000_0F00);
    chk(!aw_ready && !w_ready && !oaw_valid && !ow_valid, "R11 held", {aw_ready, w_ready}, 0);

    // R1 field placement, R3 reserved mode
    cfg_wr(32'hFFFF_FFFF);
    #1 chk(cfg_rdata == cfg_word(4'hF, 2'b11, 1'b1), "R3 reserved mode", cfg_rdata, cfg_word(4'hF, 2'b11, 1'b1));
    cfg_wr(32'h0000_0318);
    #1 chk(cfg_rdata == 32'h0000_0318, "R1 fields", cfg_rdata, 32'h0000_0318);
    @(negedge clk); blk_rst = 1'b0;
    // R2 write ignored outside hold
    cfg_wr(32'h0000_0500);
    #1 chk(cfg_rdata == 32'h0000_0318, "R2 ignored", cfg_rdata, 32'h0000_0318);

    // R4 mode 00: 4-beat burst
    setup(cfg_word(4'h0, 2'b00, 1'b0));
    push_aw(32'h100, 8'd3, 4'd2);
    for (int k = 0; k < 3; k++) push_w(DW'(k), 1'b0);
    #1 chk(!oaw_valid, "R4 held before last", 32'(oaw_valid), 0);
    @(negedge clk);
    push_w(DW'(3), 1'b1);
    pop_aw(32'h100, 4'd2, "R4 release at last");
    ow_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1 chk(ow_valid && ow_data == DW'(k), "R7 data out", ow_data, 32'(k));
      @(negedge clk);
    end
    ow_ready = 1'b0;

    // R5 threshold 2 beats
    setup(cfg_word(4'h1, 2'b01, 1'b0));
    push_aw(32'h200, 8'd5, 4'd0);
    push_w('0, 1'b0);
    #1 chk(!oaw_valid, "R5 below threshold", 32'(oaw_valid), 0);
    @(negedge clk);
    push_w('0, 1'b0);
    pop_aw(32'h200, 4'd0, "R5 at threshold");

    // R6 threshold 16, 8-beat burst
    setup(cfg_word(4'hF, 2'b01, 1'b0));
    push_aw(32'h300, 8'd7, 4'd0);
    for (int k = 0; k < 7; k++) push_w('0, 1'b0);
    #1 chk(!oaw_valid, "R6 before last", 32'(oaw_valid), 0);
    @(negedge clk);
    push_w('0, 1'b1);
    pop_aw(32'h300, 4'd0, "R6 early last");

    // R7 data before command
    setup(cfg_word(4'h0, 2'b00, 1'b0));
    @(negedge clk);
    push_w('0, 1'b0); push_w('0, 1'b1);
    #1 chk(!oaw_valid, "R7 no cmd yet", 32'(oaw_valid), 0);
    push_aw(32'h400, 8'd1, 4'd1);
    pop_aw(32'h400, 4'd1, "R7 early data");

    // R8 promotion enabled
    setup(cfg_word(4'h0, 2'b00, 1'b1));
    for (int k = 0; k < 3; k++) push_aw(AW'(32'h500 + k), 8'd0, 4'd1);
    @(negedge clk); aw_qos = 4'd6;
    @(negedge clk);
    for (int k = 0; k < 3; k++) push_w('0, 1'b1);
    for (int k = 0; k < 3; k++) pop_aw(AW'(32'h500 + k), 4'd6, "R8 promoted");

    // R9 promotion disabled
    setup(cfg_word(4'h0, 2'b00, 1'b0));
    aw_qos = 4'd1;
    for (int k = 0; k < 2; k++) push_aw(AW'(32'h600 + k), 8'd0, 4'd1);
    @(negedge clk); aw_qos = 4'd6;
    @(negedge clk);
    push_aw(32'h602, 8'd0, 4'd6);
    for (int k = 0; k < 3; k++) push_w('0, 1'b1);
    pop_aw(32'h600, 4'd1, "R9 kept");
    pop_aw(32'h601, 4'd1, "R9 kept");
    pop_aw(32'h602, 4'd6, "R9 new");

    // R10 full queue and full FIFO
    setup(cfg_word(4'h0, 2'b00, 1'b0));
    for (int k = 0; k < QD; k++) push_aw(AW'(k), 8'd0, 4'd0);
    #1 chk(!aw_ready, "R10 queue full", 32'(aw_ready), 0);
    @(negedge clk);
    for (int k = 0; k < FD; k++) push_w('0, 1'b0);
    #1 chk(!w_ready, "R10 fifo full", 32'(w_ready), 0);
    // R11 hold discards content
    @(negedge clk); blk_rst = 1'b1;
    @(negedge clk); blk_rst = 1'b0;
    #1 chk(aw_ready && w_ready && !oaw_valid && !ow_valid, "R11 cleared",
           {aw_ready, w_ready, oaw_valid, ow_valid}, 32'hC);

    // random in-order traffic, threshold 4 beats
    setup(cfg_word(4'h3, 2'b01, 1'b0));
    for (int b = 0; b < NB; b++) rlen[b] = 8'($urandom % 8);
    rnd_on = 1'b1;
    fork
      for (int b = 0; b < NB; b++) begin
        push_aw(AW'(b * 64), rlen[b], 4'd0);
        repeat ($urandom % 3) @(negedge clk);
      end
      begin
        @(negedge clk);
        for (int b = 0; b < NB; b++)
          for (int k = 0; k <= int'(rlen[b]); k++) push_w(beat_val(b, k), k == int'(rlen[b]));
      end
      while (!done) begin
        @(negedge clk);
        oaw_ready = 1'($urandom % 2);
        ow_ready  = 1'($urandom % 2);
        if (ai == NB && wi == NB) done = 1'b1;
      end
    join
    rnd_on = 1'b0; oaw_ready = 1'b0; ow_ready = 1'b0;
    chk(ai == NB && wi == NB, "R7 all transferred", 32'(ai), NB);
    summary();
  end
endmodule